// File: doc/BRIEF.md
# Streaming Bit-Permutation Reorderer

This block accepts a stream of frames of N = 2^ADDR_BITS samples, one sample per accepted beat, and emits the same frames with their samples rearranged. The rearrangement is a fixed shuffle of the index bits. Output position p is taken from the input sample whose index has bit `tgt(k)` equal to bit k of p, for every k. Elaboration picks the shuffle: identity, full bit reversal, a square transpose that swaps the upper and lower halves of the index, or a custom table of 8-bit target fields.

Storage is a single on-chip memory of 2N words used as two banks. While one bank is filled in arrival order, the other is drained in shuffled order, and the two swap at every frame boundary. A frame therefore leaves the block while the next one arrives, and a continuous input stream gives a continuous output stream. Output beats advance with input beats, so the last frame is pushed out by the frame after it. The read path has one or two register stages, chosen by a parameter. The valid flag and the frame-start flag are delayed by the same number of stages.

Top module: `bitperm_reorder`

## Requirements
- R1: After reset, `out_valid` and `out_sof` are low, and they stay low until input arrives.
- R2: The first N input beats after reset produce no output beat.
- R3: Output position p of a frame equals the input sample at index a, where a[tgt(k)] = p[k] for every bit k of the index.
- R4: With PERM_KIND = PK_BITREV, tgt(k) = ADDR_BITS-1-k. For N=16, output position p carries input index {p[0],p[1],p[2],p[3]}.
- R5: With PERM_KIND = PK_TRANSPOSE, tgt(k) = (k + ADDR_BITS/2) mod ADDR_BITS. For N=16, output position p carries input index {p[1:0],p[3:2]}.
- R6: With continuous input, the first beat of the first output frame appears N + RD_LAT cycles after the first input beat of that frame.
- R7: `out_sof` is high only together with `out_valid`, and exactly on output position 0 of every frame.
- R8: With continuous input, from the first output beat onward `out_valid` stays high with no gap across frame boundaries.
- R9: Idle input cycles pause the block without losing samples. After the first frame, each accepted beat yields exactly one output beat RD_LAT cycles later, and `out_valid` is never high without such a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DATA_W | Input sample, frames in arrival order |
| out_valid | output | 1 | Output sample present this cycle |
| out_sof | output | 1 | Output sample is position 0 of a frame |
| out_data | output | DATA_W | Output sample in shuffled order |

## Verification
Two instances run side by side on the same stream. One uses bit reversal with one read stage, the other uses the half-swap transpose with two read stages. A mistake in the shuffle table and a mistake in delay alignment therefore show up on different outputs. Every sample value is a distinct hash of its global beat number, so a sample taken from the wrong position, the wrong bank or the wrong frame never matches by accident. A gapless multi-frame run separates correct bank swapping and continuous output from designs that drop or repeat a frame. An irregular idle pattern separates designs whose counters advance only on accepted beats from those that advance every cycle.

// File: rtl/bitperm_pkg.sv
`timescale 1ns/1ps
package bitperm_pkg;

   // Selects how output-position bits are routed to memory address bits.
   typedef enum logic [1:0] {
      PK_IDENTITY  = 2'd0,
      PK_BITREV    = 2'd1,
      PK_TRANSPOSE = 2'd2,
      PK_CUSTOM    = 2'd3
   } perm_kind_e;

   // Width of one entry of a custom routing table.
   localparam int unsigned MAP_FIELD_W = 8;

endpackage

// File: rtl/bitperm_addr_map.sv
`timescale 1ns/1ps
// Routes each bit of an output position onto a memory address bit.
module bitperm_addr_map
   import bitperm_pkg::*;
#(
   parameter int unsigned ADDR_BITS = 4,
   parameter perm_kind_e  PERM_KIND = PK_BITREV,
   parameter logic [ADDR_BITS*MAP_FIELD_W-1:0] PERM_MAP = '0
)(
   input  logic [ADDR_BITS-1:0] pos,
   output logic [ADDR_BITS-1:0] addr
);

   // Address bit that receives position bit k.
   function automatic int unsigned tgt_of(int unsigned k);
      case (PERM_KIND)
         PK_BITREV:    return ADDR_BITS - 1 - k;
         PK_TRANSPOSE: return (k + ADDR_BITS / 2) % ADDR_BITS;
         PK_CUSTOM:    return int'(PERM_MAP[k*MAP_FIELD_W +: MAP_FIELD_W]);
         default:      return k;
      endcase
   endfunction

   // True when every target is in range and no target repeats.
   function automatic bit perm_ok();
      logic [255:0] seen;
      seen = '0;
      for (int unsigned k = 0; k < ADDR_BITS; k++) begin
         if (tgt_of(k) >= ADDR_BITS) return 1'b0;
         if (seen[tgt_of(k)]) return 1'b0;
         seen[tgt_of(k)] = 1'b1;
      end
      return 1'b1;
   endfunction

   if (!perm_ok()) begin : g_bad_map
      $error("bitperm_addr_map: routing table is not a permutation");
   end

   if (PERM_KIND == PK_TRANSPOSE && (ADDR_BITS % 2) != 0) begin : g_bad_tp
      $error("bitperm_addr_map: transpose needs an even number of index bits");
   end

   always_comb begin
      addr = '0;
      for (int unsigned k = 0; k < ADDR_BITS; k++) begin
         addr[tgt_of(k)] = pos[k];
      end
   end

endmodule

// File: rtl/bitperm_frame_ctrl.sv
`timescale 1ns/1ps
// Counts beats within a frame, flips the bank at every frame end and
// allows reads once one full frame has been stored.
module bitperm_frame_ctrl #(
   parameter int unsigned ADDR_BITS = 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic [ADDR_BITS-1:0] pos,
   output logic                 wr_bank,
   output logic                 rd_go,
   output logic                 rd_first
);

   localparam logic [ADDR_BITS-1:0] LAST_POS = '1;

   logic [ADDR_BITS-1:0] pos_q;
   logic                 bank_q;
   logic                 primed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q    <= '0;
         bank_q   <= 1'b0;
         primed_q <= 1'b0;
      end else if (in_valid) begin
         pos_q <= pos_q + 1'b1;
         if (pos_q == LAST_POS) begin
            bank_q   <= ~bank_q;
            primed_q <= 1'b1;
         end
      end
   end

   assign pos      = pos_q;
   assign wr_bank  = bank_q;
   assign rd_go    = in_valid & primed_q;
   assign rd_first = rd_go & (pos_q == '0);

endmodule

// File: rtl/bitperm_pingpong_ram.sv
`timescale 1ns/1ps
// Two N-word banks in one array: bank select is the top address bit.
module bitperm_pingpong_ram #(
   parameter int unsigned ADDR_BITS = 4,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned RD_LAT    = 1
)(
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [ADDR_BITS:0]   wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd_en,
   input  logic [ADDR_BITS:0]   rd_addr,
   output logic [DATA_W-1:0]    rd_data
);

   localparam int unsigned DEPTH = 2 << ADDR_BITS;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_q1;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_q1 <= mem[rd_addr];
   end

   if (RD_LAT == 1) begin : g_lat1
      assign rd_data = rd_q1;
   end else begin : g_lat2
      logic [DATA_W-1:0] rd_q2;
      always_ff @(posedge clk) begin
         rd_q2 <= rd_q1;
      end
      assign rd_data = rd_q2;
   end

endmodule

// File: rtl/bitperm_reorder.sv
`timescale 1ns/1ps
module bitperm_reorder
   import bitperm_pkg::*;
#(
   parameter int unsigned ADDR_BITS = 4,
   parameter int unsigned DATA_W    = 16,
   parameter perm_kind_e  PERM_KIND = PK_BITREV,
   parameter logic [ADDR_BITS*MAP_FIELD_W-1:0] PERM_MAP = '0,
   parameter int unsigned RD_LAT    = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_sof,
   output logic [DATA_W-1:0] out_data
);

   if (ADDR_BITS < 2 || ADDR_BITS > 16) begin : g_bad_ab
      $error("bitperm_reorder: ADDR_BITS must lie in 2..16");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("bitperm_reorder: DATA_W must be positive");
   end
   if (RD_LAT < 1 || RD_LAT > 2) begin : g_bad_lat
      $error("bitperm_reorder: RD_LAT must be 1 or 2");
   end

   logic [ADDR_BITS-1:0] pos;
   logic [ADDR_BITS-1:0] perm_addr;
   logic                 wr_bank;
   logic                 rd_go;
   logic                 rd_first;

   bitperm_frame_ctrl #(
      .ADDR_BITS (ADDR_BITS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .pos      (pos),
      .wr_bank  (wr_bank),
      .rd_go    (rd_go),
      .rd_first (rd_first)
   );

   bitperm_addr_map #(
      .ADDR_BITS (ADDR_BITS),
      .PERM_KIND (PERM_KIND),
      .PERM_MAP  (PERM_MAP)
   ) u_map (
      .pos  (pos),
      .addr (perm_addr)
   );

   bitperm_pingpong_ram #(
      .ADDR_BITS (ADDR_BITS),
      .DATA_W    (DATA_W),
      .RD_LAT    (RD_LAT)
   ) u_ram (
      .clk     (clk),
      .wr_en   (in_valid),
      .wr_addr ({wr_bank, pos}),
      .wr_data (in_data),
      .rd_en   (rd_go),
      .rd_addr ({~wr_bank, perm_addr}),
      .rd_data (out_data)
   );

   // Flags travel alongside the read pipeline.
   logic [RD_LAT-1:0] vld_sr;
   logic [RD_LAT-1:0] sof_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_sr <= '0;
         sof_sr <= '0;
      end else begin
         vld_sr[0] <= rd_go;
         sof_sr[0] <= rd_first;
         for (int unsigned i = 1; i < RD_LAT; i++) begin
            vld_sr[i] <= vld_sr[i-1];
            sof_sr[i] <= sof_sr[i-1];
         end
      end
   end

   assign out_valid = vld_sr[RD_LAT-1];
   assign out_sof   = sof_sr[RD_LAT-1];

endmodule

// File: rtl/bitperm_reorder_chk.sv
`timescale 1ns/1ps
module bitperm_reorder_chk #(
   parameter int unsigned ADDR_BITS = 4,
   parameter int unsigned RD_LAT    = 1
)(
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic out_valid,
   input logic out_sof
);

   localparam int unsigned N = 1 << ADDR_BITS;

   logic [ADDR_BITS:0]   beats_q;
   logic [ADDR_BITS-1:0] ocnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beats_q <= '0;
         ocnt_q  <= '0;
      end else begin
         if (in_valid && beats_q <= (ADDR_BITS+1)'(N)) beats_q <= beats_q + 1'b1;
         if (out_valid) ocnt_q <= ocnt_q + 1'b1;
      end
   end

   AST_FIRST_FRAME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (beats_q <= (ADDR_BITS+1)'(N)) |-> !out_valid); // R2

   AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, RD_LAT)); // R9

   AST_PRIMED_BEAT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid, RD_LAT) && $past(beats_q, RD_LAT) >= (ADDR_BITS+1)'(N)) |-> out_valid); // R8

   AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid); // R7

   AST_SOF_ON_POS0: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sof == (ocnt_q == '0))); // R7

endmodule

bind bitperm_reorder bitperm_reorder_chk #(
   .ADDR_BITS (ADDR_BITS),
   .RD_LAT    (RD_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_sof   (out_sof)
);

// File: tb/bitperm_reorder_tb.sv
`timescale 1ns/1ps
module bitperm_reorder_tb;
   import bitperm_pkg::*;

   localparam int AB   = 4;
   localparam int N    = 1 << AB;
   localparam int DW   = 16;
   localparam int HIST = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic va, sa, vb, sb;
   logic [DW-1:0] da, db;

   always #2.5 clk = ~clk;

   bitperm_reorder #(.ADDR_BITS(AB), .DATA_W(DW), .PERM_KIND(PK_BITREV), .RD_LAT(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(va), .out_sof(sa), .out_data(da));

   bitperm_reorder #(.ADDR_BITS(AB), .DATA_W(DW), .PERM_KIND(PK_TRANSPOSE), .RD_LAT(2)) u_dut_tp (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(vb), .out_sof(sb), .out_data(db));

   int n_cmp = 0;
   int n_bad = 0;
   logic [DW-1:0] hist [HIST];
   int in_beats, ob_a, ob_b;
   logic cur_flag, sh0, sh1;
   int salt;

   function automatic int src_rev(int p);
      int a = 0;
      for (int k = 0; k < AB; k++) if (p[k]) a |= 1 << (AB - 1 - k);
      return a;
   endfunction

   function automatic int src_tp(int p);
      int a = 0;
      for (int k = 0; k < AB; k++) if (p[k]) a |= 1 << ((k + AB/2) % AB);
      return a;
   endfunction

   function automatic logic [DW-1:0] gen_val(int beat, int s);
      logic [31:0] t = beat * 40503;
      return t[DW-1:0] ^ s[DW-1:0];
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      in_beats = 0; ob_a = 0; ob_b = 0;
      cur_flag = 1'b0; sh0 = 1'b0; sh1 = 1'b0;
   endtask

   // One cycle: check outputs against the model, then drive the next input.
   task automatic step(bit v, string tag);
      int fr, p;
      @(negedge clk);
      sh1 = sh0;
      sh0 = cur_flag;
      check(va == sh0, tag, "bitrev out_valid", int'(va), int'(sh0));
      if (sh0) begin
         fr = ob_a / N; p = ob_a % N;
         check(da == hist[(fr*N + src_rev(p)) % HIST], "R3 R4", "bitrev data",
               int'(da), int'(hist[(fr*N + src_rev(p)) % HIST]));
         check(sa == (p == 0), "R7", "bitrev out_sof", int'(sa), int'(p == 0));
         ob_a++;
      end
      check(vb == sh1, tag, "transpose out_valid", int'(vb), int'(sh1));
      if (sh1) begin
         fr = ob_b / N; p = ob_b % N;
         check(db == hist[(fr*N + src_tp(p)) % HIST], "R3 R5", "transpose data",
               int'(db), int'(hist[(fr*N + src_tp(p)) % HIST]));
         check(sb == (p == 0), "R7", "transpose out_sof", int'(sb), int'(p == 0));
         ob_b++;
      end
      in_valid = v;
      if (v) begin
         in_data = gen_val(in_beats, salt);
         hist[in_beats % HIST] = in_data;
         cur_flag = (in_beats >= N);
         in_beats++;
      end else begin
         in_data = 16'hDEAD;
         cur_flag = 1'b0;
      end
   endtask

   task automatic t_reset();
      salt = 16'h1111;
      do_reset();
      repeat (3) step(1'b0, "R1");
      check(!va && !sa, "R1", "bitrev flags after reset", int'({va, sa}), 0);
      check(!vb && !sb, "R1", "transpose flags after reset", int'({vb, sb}), 0);
   endtask

   task automatic t_first_frame();
      salt = 16'h2C5A;
      do_reset();
      for (int i = 0; i < N + 1; i++) step(1'b1, "R2");
      check(ob_a == 0 && ob_b == 0, "R2", "outputs during first frame", ob_a + ob_b, 0);
   endtask

   task automatic t_latency();
      int first_a = -1;
      int first_b = -1;
      salt = 16'h0F0F;
      do_reset();
      for (int i = 0; i < N + 4; i++) begin
         step(1'b1, "R6");
         if (va && first_a < 0) first_a = i;
         if (vb && first_b < 0) first_b = i;
      end
      check(first_a == N + 1, "R6", "bitrev first output cycle", first_a, N + 1);
      check(first_b == N + 2, "R6", "transpose first output cycle", first_b, N + 2);
   endtask

   task automatic t_gapless();
      salt = 16'h7A31;
      do_reset();
      for (int i = 0; i < 5*N + 4; i++) step(1'b1, "R8");
      check(ob_a == 4*N + 3, "R8", "bitrev continuous output count", ob_a, 4*N + 3);
      check(ob_b == 4*N + 2, "R8", "transpose continuous output count", ob_b, 4*N + 2);
   endtask

   task automatic t_stall();
      int acc = 0;
      salt = 16'h4B6D;
      do_reset();
      for (int i = 0; i < 6*N; i++) begin
         bit v = !((i % 5) == 2 || (i % 7) == 0);
         step(v, "R9");
         if (v) acc++;
      end
      step(1'b0, "R9");
      step(1'b0, "R9");
      step(1'b0, "R9");
      check(ob_a == acc - N, "R9", "bitrev outputs after stalls", ob_a, acc - N);
      check(ob_b == acc - N, "R9", "transpose outputs after stalls", ob_b, acc - N);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      t_reset();
      t_first_frame();
      t_latency();
      t_gapless();
      t_stall();
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

endmodule